// File: doc/BRIEF.md
# Pull-Driven Layer Interconnect Arbiter

This block joins one lower protocol layer to several upper-layer sources in a transmit stack where the lower layer pulls data, not the upper layers pushing it. Each upper source raises a request by clearing its empty flag. The block picks one requester in rotating order and tells the lower layer that a frame is waiting. When the lower layer sends its pull strobe, the block passes that strobe on as a start pulse to the chosen source only. From then on it steers that source's byte stream and enable down to the lower layer through a single register stage.

The choice is locked from the start pulse until the chosen source has raised its enable and then dropped it again. While locked, further pull strobes reach only the chosen source. All other sources are ignored: they get no start, and their data and enable never appear downstream. Because the lower layer reads bytes straight from the upper source at the moment it needs them, no frame is ever copied into a buffer between layers.

Top module: `layer_link_arb`

## Requirements
- R1: After reset, and until the first pull is accepted, `dn_txen`, `dn_txd` and `src_start` are all zero. A source `i` requests when `src_empty[i]` is 0.
- R2: `dn_pending` is 1 in the cycle after a cycle in which the block was unlocked and at least one source requested. Otherwise it is 0, which includes every cycle that follows a locked cycle.
- R3: A `dn_next` high in a cycle where the block is unlocked and some source requests makes exactly one bit of `src_start` high in the next cycle. That bit is the position of the chosen source, with bit i belonging to source i. The block is locked from that cycle on.
- R4: The choice is round-robin. The search starts at the index one above the last granted source and wraps modulo NSRC. After reset it starts at source 0.
- R5: The lock holds while the chosen source has not yet raised `src_txen`, and while its `src_txen` is high. The lock is released at the first clock edge where the chosen source's `src_txen` is low after having been high.
- R6: A `dn_next` while locked produces a one-cycle start pulse, in the next cycle, on the chosen source's `src_start` bit only, whatever the other sources request.
- R7: While locked, `dn_txen` and `dn_txd` equal the chosen source's `src_txen` and its byte (bits i*W to i*W+W-1 of `src_txd`), delayed by one cycle.
- R8: The data and enable of sources that are not chosen, and the data and enable of any source while the block is unlocked, have no effect. In those cycles `dn_txen` is 0 and `dn_txd` is 0 one cycle later.
- R9: A `dn_next` while unlocked with no source requesting produces no start pulse and does not lock the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_empty | input | NSRC | Per-source empty flag, 0 means a frame is waiting |
| src_txen | input | NSRC | Per-source byte enable |
| src_txd | input | NSRC*W | Per-source byte, source i in slice i |
| src_start | output | NSRC | Registered start pulse to each source |
| dn_next | input | 1 | Pull strobe from the lower layer |
| dn_pending | output | 1 | Registered: a frame is waiting for the lower layer |
| dn_txen | output | 1 | Registered enable towards the lower layer |
| dn_txd | output | W | Registered byte towards the lower layer |

## Verification
The embedded assertions check the following on every cycle: start pulses are at most one-hot, and they appear only after a pull strobe. No start and no pending flag follow an unlocked cycle with no requests. The enable downstream stays low while unlocked, and the lock survives any cycle in which the chosen source still drives its enable. Which source wins under each request mask, that the rotating pointer advances correctly, that the bytes are routed exactly with one cycle of delay, and that the block unlocks at the right moment can only be shown by the bench's scenarios. Those scenarios sweep every request mask of a three-source configuration twice, while the sources that were not chosen drive conflicting data.

// File: rtl/lla_rr_pick.sv
module lla_rr_pick #(
  parameter int NSRC = 4,
  localparam int IW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] req,
  input  logic [IW-1:0]   last,
  output logic            any,
  output logic [IW-1:0]   idx
);
  // Scan from the farthest candidate to the nearest; the nearest one
  // above 'last' (cyclically) is written last and so wins.
  always_comb begin
    int j;
    any = |req;
    idx = '0;
    for (int k = NSRC; k >= 1; k--) begin
      j = int'(last) + k;
      if (j >= NSRC) j = j - NSRC;
      if (req[IW'(j)]) idx = IW'(j);
    end
  end
endmodule

// File: rtl/lla_data_mux.sv
module lla_data_mux #(
  parameter int NSRC = 4,
  parameter int W    = 8,
  localparam int IW = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              route,
  input  logic [IW-1:0]     sel,
  input  logic [NSRC*W-1:0] src_txd,
  input  logic [NSRC-1:0]   src_txen,
  output logic [W-1:0]      dn_txd,
  output logic              dn_txen
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dn_txd  <= '0;
      dn_txen <= 1'b0;
    end else if (route) begin
      dn_txd  <= src_txd[int'(sel)*W +: W];
      dn_txen <= src_txen[sel];
    end else begin
      dn_txd  <= '0;
      dn_txen <= 1'b0;
    end
  end

  AST_MUX_QUIET: assert property (@(posedge clk) disable iff (rst)
    !route |=> (!dn_txen && dn_txd == '0)); // R8
endmodule

// File: rtl/layer_link_arb.sv
module layer_link_arb #(
  parameter int NSRC = 4,
  parameter int W    = 8,
  localparam int IW = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_empty,
  input  logic [NSRC-1:0]   src_txen,
  input  logic [NSRC*W-1:0] src_txd,
  output logic [NSRC-1:0]   src_start,
  input  logic              dn_next,
  output logic              dn_pending,
  output logic              dn_txen,
  output logic [W-1:0]      dn_txd
);
  logic [NSRC-1:0] req;
  logic            req_any;
  logic [IW-1:0]   pick;
  logic [IW-1:0]   last_q, grant_q, target;
  logic            locked_q, en_seen_q, pending_q;
  logic [NSRC-1:0] start_q;

  assign req    = ~src_empty;
  assign target = locked_q ? grant_q : pick;

  lla_rr_pick #(.NSRC(NSRC)) u_pick (
    .req  (req),
    .last (last_q),
    .any  (req_any),
    .idx  (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q   <= '0;
      pending_q <= 1'b0;
      locked_q  <= 1'b0;
      en_seen_q <= 1'b0;
      grant_q   <= '0;
      last_q    <= IW'(NSRC - 1);
    end else begin
      start_q <= '0;
      if (dn_next && (locked_q || req_any)) start_q[target] <= 1'b1;
      pending_q <= !locked_q && req_any;
      if (!locked_q) begin
        if (dn_next && req_any) begin
          locked_q  <= 1'b1;
          en_seen_q <= 1'b0;
          grant_q   <= pick;
          last_q    <= pick;
        end
      end else if (src_txen[grant_q]) begin
        en_seen_q <= 1'b1;
      end else if (en_seen_q) begin
        locked_q  <= 1'b0;
        en_seen_q <= 1'b0;
      end
    end
  end

  assign src_start  = start_q;
  assign dn_pending = pending_q;

  lla_data_mux #(.NSRC(NSRC), .W(W)) u_mux (
    .clk      (clk),
    .rst      (rst),
    .route    (locked_q),
    .sel      (grant_q),
    .src_txd  (src_txd),
    .src_txen (src_txen),
    .dn_txd   (dn_txd),
    .dn_txen  (dn_txen)
  );

  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_start)); // R3
  AST_START_NEEDS_PULL: assert property (@(posedge clk) disable iff (rst)
    !dn_next |=> (src_start == '0)); // R6
  AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (rst)
    (!locked_q && src_empty == '1) |=> (src_start == '0 && !dn_pending)); // R9
  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (rst)
    (locked_q && src_txen[grant_q]) |=> locked_q); // R5
  AST_PENDING_OFF_LOCKED: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> !dn_pending); // R2
endmodule

// File: tb/sim_layer_link_arb.sv
module sim_layer_link_arb;
  localparam int  NSRC = 3;
  localparam int  W    = 8;
  localparam time TCLK = 8ns;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NSRC-1:0]   src_empty = '1;
  logic [NSRC-1:0]   src_txen  = '0;
  logic [NSRC*W-1:0] src_txd   = '0;
  logic [NSRC-1:0]   src_start;
  logic              dn_next = 1'b0;
  logic              dn_pending, dn_txen;
  logic [W-1:0]      dn_txd;

  int tests = 0, fails = 0;
  int last_g = NSRC - 1;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  layer_link_arb #(.NSRC(NSRC), .W(W)) u0 (
    .clk(clk), .rst(rst), .src_empty(src_empty), .src_txen(src_txen),
    .src_txd(src_txd), .src_start(src_start), .dn_next(dn_next),
    .dn_pending(dn_pending), .dn_txen(dn_txen), .dn_txd(dn_txd)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic int rr_expect(int mask, int last);
    for (int k = 1; k <= NSRC; k++) begin
      int j = (last + k) % NSRC;
      if (mask[j]) return j;
    end
    return -1;
  endfunction

  // Non-chosen sources drive junk with enable high to prove they are ignored.
  task automatic drive_noise(int g, bit gen, logic [W-1:0] gd);
    for (int s = 0; s < NSRC; s++) begin
      if (s == g) begin
        src_txen[s] = gen;
        src_txd[s*W +: W] = gd;
      end else begin
        src_txen[s] = 1'b1;
        src_txd[s*W +: W] = 8'hE0 | 8'(s);
      end
    end
  endtask

  task automatic frame(int mask, int len);
    int g = rr_expect(mask, last_g);
    @(negedge clk);
    src_empty = ~NSRC'(mask);
    drive_noise(-1, 1'b0, '0);          // all sources noisy while unlocked
    tick();
    chk("R2 pending", dn_pending, 1);
    chk("R8 unlocked txen", dn_txen, 0);
    chk("R8 unlocked txd", dn_txd, 0);
    @(negedge clk);
    dn_next = 1'b1;
    tick();
    chk("R3 R4 start", src_start, NSRC'(1) << g);
    @(negedge clk);
    dn_next = 1'b1;                     // pull again while locked
    src_empty = '0;                     // everyone requests now
    drive_noise(g, 1'b0, '0);
    tick();
    chk("R6 locked start", src_start, NSRC'(1) << g);
    chk("R2 pending locked", dn_pending, 0);
    @(negedge clk);
    dn_next = 1'b0;
    tick();                             // chosen enable still low: lock must hold
    chk("R6 no pull", src_start, 0);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      drive_noise(g, 1'b1, 8'(16 * g + i + 1));
      tick();
      chk("R7 txen", dn_txen, 1);
      chk("R7 txd", dn_txd, 16 * g + i + 1);
      chk("R5 R2 held", dn_pending, 0);
    end
    @(negedge clk);
    src_empty = '1;
    src_txen  = '0;
    tick();                             // unlocks at this edge
    chk("R7 end txen", dn_txen, 0);
    @(negedge clk);
    dn_next = 1'b1;                     // no requests: must not start
    src_txen = '1;
    tick();
    chk("R5 unlocked txen", dn_txen, 0);
    chk("R9 idle start", src_start, 0);
    chk("R2 idle pending", dn_pending, 0);
    @(negedge clk);
    dn_next = 1'b0;
    src_txen = '0;
    tick();
    chk("R9 no lock", dn_txen, 0);
    last_g = g;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset start", src_start, 0);
    chk("R1 reset txen", dn_txen, 0);
    chk("R1 reset pending", dn_pending, 0);
    @(negedge clk);
    rst = 1'b0;
    tick();
    chk("R1 after reset txd", dn_txd, 0);
    for (int rep = 0; rep < 2; rep++)
      for (int m = 1; m < (1 << NSRC); m++)
        frame(m, 2 + ((m + rep) % 3));
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule